// File: doc/BRIEF.md
# Link Start-Up Reset Sequencer

This block brings one direction of a source-synchronous packet interface out of power-up in a fixed order. It first holds the local PLL in reset until the reference clock has been stable for a programmable number of cycles. It then releases the PLL and waits for lock. Next it waits until every auxiliary clock reports stable. Finally it lets a minimum number of slowest-clock cycles pass before it releases the active-low core reset. That guard count is kept by a counter that runs in the slow clock domain, and the handshake into and out of that domain crosses through two-flop synchronizers.

Once the core is out of reset, a configuration-hold request keeps the core in a state where framing is suppressed. On the transmit side this means the core keeps sending training. On the receive side it means no valid status is sent. The hold lasts until software drops the request. While the core reset is asserted, the block also supplies the 2-bit status code that the receive side drives during reset. A build option removes the PLL phases for variants that have no PLL. Losing lock at any point after the lock phase throws the sequence back to its power-up state.

Top module: `link_bringup_seq`

## Requirements
- R1: While `por_n` is low, `phase` is 0 (RESET), `pll_rst` is 1 (when a PLL is present), `core_rst_n` is 0 and `suppress_frame` is 1.
- R2: With a PLL present, the sequencer leaves RESET for PLL_WAIT on the SETTLE_CYCLES-th consecutive rising `clk` edge at which `ref_stable` is sampled high. A single low sample restarts the count. `pll_rst` is 0 in every phase other than RESET.
- R3: In PLL_WAIT (phase 1) the sequencer stays put while `pll_locked` is low. It moves to CLK_WAIT (phase 2) on the first edge at which `pll_locked` is high.
- R4: In CLK_WAIT the sequencer stays put until every bit of `aux_stable` is high. It then enters GUARD (phase 3) on the next edge.
- R5: `core_rst_n` rises no earlier than GUARD_CYCLES `slow_clk` periods after GUARD is entered. The guard counter is clocked by `slow_clk`, and the handshake crosses through two-flop synchronizers both ways.
- R6: `hold_code` is 2'b11 whenever `core_rst_n` is 0, and 2'b00 whenever it is 1.
- R7: When the guard completes with `cfg_hold` high, the sequencer enters CONFIG_HOLD (phase 4) with `core_rst_n` = 1. `suppress_frame` is 1 in every phase except RUN.
- R8: From CONFIG_HOLD, a low `cfg_hold` moves to RUN (phase 5) on the next edge. From RUN, a high `cfg_hold` moves back to CONFIG_HOLD. `core_rst_n` stays 1 in both cases.
- R9: With HAS_PLL = 0, `pll_rst` is always 0 and `pll_locked` is ignored. RESET goes to CLK_WAIT on the first edge after `por_n` rises.
- R10: With a PLL present, `pll_locked` low in CLK_WAIT, GUARD, CONFIG_HOLD or RUN returns the sequencer to RESET on the next edge. This reasserts both resets, takes priority over `cfg_hold`, and makes the settle count start again.
- R11: `phase` is 3 bits wide and encodes RESET=0, PLL_WAIT=1, CLK_WAIT=2, GUARD=3, CONFIG_HOLD=4, RUN=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock that runs the phase machine |
| slow_clk | input | 1 | Slowest clock of the core; times the guard interval |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ref_stable | input | 1 | Reference clock reported stable |
| pll_locked | input | 1 | PLL lock indication |
| aux_stable | input | NUM_AUX | One stable flag per auxiliary clock |
| cfg_hold | input | 1 | Software request to keep the core in configuration hold |
| pll_rst | output | 1 | Active-high PLL reset |
| core_rst_n | output | 1 | Active-low core reset |
| hold_code | output | 2 | Status code to drive while the core is in reset |
| suppress_frame | output | 1 | Block framing attempts and valid status |
| phase | output | 3 | Current sequencer phase |

## Verification
The bench uses SETTLE_CYCLES = 8, GUARD_CYCLES = 5 and three auxiliary clocks, with `slow_clk` at one third of the `clk` rate. These values make an exact edge count of the settle interval practical, including a restart partway through. They also bring the whole guard crossing within a few dozen cycles, so its elapsed time can be bounded from both sides. A second instance built with HAS_PLL = 0 shares the stimulus. It shows the PLL phases being skipped and the lock input being ignored, while the first instance is repeatedly thrown back to RESET by lock loss.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  typedef enum logic [2:0] {
    PH_RESET    = 3'd0,
    PH_PLL_WAIT = 3'd1,
    PH_CLK_WAIT = 3'd2,
    PH_GUARD    = 3'd3,
    PH_CFG_HOLD = 3'd4,
    PH_RUN      = 3'd5
  } phase_e;

  localparam logic [1:0] CODE_IN_RESET = 2'b11;
  localparam logic [1:0] CODE_RELEASED = 2'b00;

  // Status code the receive side drives, chosen by the core reset level.
  function automatic logic [1:0] status_code(input logic core_in_reset);
    return core_in_reset ? CODE_IN_RESET : CODE_RELEASED;
  endfunction

  // Phases in which a lost lock sends the sequence back to power-up.
  function automatic logic lock_required(input phase_e ph);
    return (ph == PH_CLK_WAIT) || (ph == PH_GUARD) ||
           (ph == PH_CFG_HOLD) || (ph == PH_RUN);
  endfunction

endpackage

// File: rtl/lss_bit_sync.sv
module lss_bit_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lss_settle_timer.sv
module lss_settle_timer #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stable,
  output logic done
);

  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Count consecutive stable samples; saturate at the last value.
  function automatic logic [CW-1:0] advance(input logic en, input logic st,
                                            input logic [CW-1:0] c);
    if (!en || !st) return '0;
    if (c == LAST)  return c;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= advance(enable, stable, cnt_q);
  end

  assign done = enable && stable && (cnt_q == LAST);

  p_settle_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_settle_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stable |=> cnt_q == '0);

endmodule

// File: rtl/lss_guard_counter.sv
module lss_guard_counter #(
  parameter int unsigned GUARD_CYCLES = 8
) (
  input  logic slow_clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);

  localparam int unsigned GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] TARGET = GW'(GUARD_CYCLES);

  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_d;
  logic          done_q;

  function automatic logic [GW-1:0] tick(input logic run, input logic [GW-1:0] c);
    if (!run)        return '0;
    if (c == TARGET) return c;
    return c + 1'b1;
  endfunction

  assign cnt_d = tick(go, cnt_q);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= go && (cnt_d == TARGET);
    end
  end

  assign done = done_q;

  p_guard_cap_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    cnt_q <= TARGET);

  p_guard_done_go_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(go));

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1024,
  parameter int unsigned GUARD_CYCLES  = 8,
  parameter int unsigned NUM_AUX       = 3,
  parameter int unsigned HAS_PLL       = 1
) (
  input  logic               clk,
  input  logic               slow_clk,
  input  logic               por_n,
  input  logic               ref_stable,
  input  logic               pll_locked,
  input  logic [NUM_AUX-1:0] aux_stable,
  input  logic               cfg_hold,
  output logic               pll_rst,
  output logic               core_rst_n,
  output logic [1:0]         hold_code,
  output logic               suppress_frame,
  output logic [2:0]         phase
);

  localparam bit USE_PLL = (HAS_PLL != 0);

  phase_e state_q, state_d;

  // Named internal events
  logic settle_done;
  logic all_aux;
  logic lock_lost;
  logic guard_req_q;
  logic guard_go_slow;
  logic guard_done_slow;
  logic guard_done_sync;
  logic guard_armed_q;
  logic guard_complete;

  assign all_aux   = &aux_stable;
  assign lock_lost = USE_PLL && !pll_locked && lock_required(state_q);

  lss_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (por_n),
    .enable (USE_PLL && (state_q == PH_RESET)),
    .stable (ref_stable),
    .done   (settle_done)
  );

  // Guard handshake: request into slow domain, completion back out.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) guard_req_q <= 1'b0;
    else        guard_req_q <= (state_q == PH_GUARD);
  end

  lss_bit_sync #(.WIDTH(1), .STAGES(2)) u_sync_to_slow (
    .clk   (slow_clk),
    .rst_n (por_n),
    .d     (guard_req_q),
    .q     (guard_go_slow)
  );

  lss_guard_counter #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .slow_clk (slow_clk),
    .rst_n    (por_n),
    .go       (guard_go_slow),
    .done     (guard_done_slow)
  );

  lss_bit_sync #(.WIDTH(1), .STAGES(2)) u_sync_to_fast (
    .clk   (clk),
    .rst_n (por_n),
    .d     (guard_done_slow),
    .q     (guard_done_sync)
  );

  // A completion is only trusted after it was seen low in this GUARD visit,
  // so a stale flag from an earlier visit cannot release the core early.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    guard_armed_q <= 1'b0;
    else if (state_q != PH_GUARD)  guard_armed_q <= 1'b0;
    else if (!guard_done_sync)     guard_armed_q <= 1'b1;
  end

  assign guard_complete = guard_armed_q && guard_done_sync;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_RESET:    if (!USE_PLL)         state_d = PH_CLK_WAIT;
                   else if (settle_done) state_d = PH_PLL_WAIT;
      PH_PLL_WAIT: if (pll_locked)       state_d = PH_CLK_WAIT;
      PH_CLK_WAIT: if (all_aux)          state_d = PH_GUARD;
      PH_GUARD:    if (guard_complete)   state_d = cfg_hold ? PH_CFG_HOLD : PH_RUN;
      PH_CFG_HOLD: if (!cfg_hold)        state_d = PH_RUN;
      PH_RUN:      if (cfg_hold)         state_d = PH_CFG_HOLD;
      default:                           state_d = PH_RESET;
    endcase
    if (lock_lost) state_d = PH_RESET;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= PH_RESET;
    else        state_q <= state_d;
  end

  assign pll_rst        = USE_PLL && (state_q == PH_RESET);
  assign core_rst_n     = (state_q == PH_CFG_HOLD) || (state_q == PH_RUN);
  assign hold_code      = status_code(!core_rst_n);
  assign suppress_frame = (state_q != PH_RUN);
  assign phase          = state_q;

  p_pll_release_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pll_rst) |-> $past(settle_done));

  p_lock_gate_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PH_PLL_WAIT && !pll_locked) |=> state_q == PH_PLL_WAIT);

  p_aux_gate_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PH_CLK_WAIT && !all_aux && !lock_lost) |=> state_q == PH_CLK_WAIT);

  p_core_release_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> $past(guard_done_sync));

  p_hold_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && cfg_hold && !lock_lost) |=> state_q == PH_CFG_HOLD);

  p_lock_loss_r10: assert property (@(posedge clk) disable iff (!por_n)
    lock_lost |=> (state_q == PH_RESET && !core_rst_n));

  p_phase_legal_r11: assert property (@(posedge clk) disable iff (!por_n)
    phase <= 3'd5);

endmodule

// File: tb/link_bringup_seq_bench.sv
`timescale 1ns/1ps
module link_bringup_seq_bench;

  localparam int unsigned SETTLE = 8;
  localparam int unsigned GUARD  = 5;
  localparam int unsigned NAUX   = 3;
  localparam int unsigned TCLK   = 20;
  localparam int unsigned TSLOW  = 60;

  logic clk = 1'b0;
  logic slow_clk = 1'b0;
  always #(TCLK/2)  clk = ~clk;
  always #(TSLOW/2) slow_clk = ~slow_clk;

  logic            por_n = 1'b0;
  logic            ref_stable = 1'b0;
  logic            pll_locked = 1'b0;
  logic [NAUX-1:0] aux_stable = '0;
  logic            cfg_hold = 1'b0;

  logic       pll_rst, core_rst_n, suppress_frame;
  logic [1:0] hold_code;
  logic [2:0] phase;
  logic       np_pll_rst, np_core_rst_n, np_suppress;
  logic [1:0] np_hold_code;
  logic [2:0] np_phase;

  link_bringup_seq #(.SETTLE_CYCLES(SETTLE), .GUARD_CYCLES(GUARD),
                     .NUM_AUX(NAUX), .HAS_PLL(1)) u_link_bringup_seq (
    .clk(clk), .slow_clk(slow_clk), .por_n(por_n), .ref_stable(ref_stable),
    .pll_locked(pll_locked), .aux_stable(aux_stable), .cfg_hold(cfg_hold),
    .pll_rst(pll_rst), .core_rst_n(core_rst_n), .hold_code(hold_code),
    .suppress_frame(suppress_frame), .phase(phase));

  link_bringup_seq #(.SETTLE_CYCLES(SETTLE), .GUARD_CYCLES(GUARD),
                     .NUM_AUX(NAUX), .HAS_PLL(0)) u_link_bringup_seq_nopll (
    .clk(clk), .slow_clk(slow_clk), .por_n(por_n), .ref_stable(ref_stable),
    .pll_locked(1'b0), .aux_stable(aux_stable), .cfg_hold(cfg_hold),
    .pll_rst(np_pll_rst), .core_rst_n(np_core_rst_n), .hold_code(np_hold_code),
    .suppress_frame(np_suppress), .phase(np_phase));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit np_pll_seen = 0;

  always @(negedge clk) if (por_n && np_pll_rst) np_pll_seen = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench's own view of the output set each phase implies.
  task automatic check_outputs(input int exp_ph, input string req);
    check(phase == 3'(exp_ph), {req, " phase"}, phase, exp_ph);
    check(pll_rst == (exp_ph == 0), {req, " pll_rst"}, pll_rst, exp_ph == 0);
    check(core_rst_n == (exp_ph >= 4), {req, " core_rst_n"}, core_rst_n, exp_ph >= 4);
    check(hold_code == ((exp_ph >= 4) ? 2'b00 : 2'b11), {req, " R6 hold_code"},
          hold_code, (exp_ph >= 4) ? 0 : 3);
    check(suppress_frame == (exp_ph != 5), {req, " R7 suppress_frame"},
          suppress_frame, exp_ph != 5);
  endtask

  // Vector: {lock, aux[2:0], hold, expected phase[2:0], max cycles[7:0]}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 3'b111, 1'b1, 3'd4, 8'd3},   // R7 stays in hold
    {1'b1, 3'b111, 1'b0, 3'd5, 8'd3},   // R8 hold released
    {1'b1, 3'b111, 1'b1, 3'd4, 8'd3},   // R8 back into hold
    {1'b1, 3'b111, 1'b0, 3'd5, 8'd3},   // R8 run again
    {1'b0, 3'b111, 1'b0, 3'd0, 8'd3},   // R10 lock lost in run
    {1'b1, 3'b111, 1'b0, 3'd1, 8'd20},  // R10 settle restarted
    {1'b1, 3'b111, 1'b0, 3'd5, 8'd60},  // full relock to run
    {1'b0, 3'b111, 1'b1, 3'd0, 8'd3}    // R10 lock loss beats hold
  };

  initial begin
    int t0, t1, el;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_outputs(0, "R1");
    check(np_pll_rst == 1'b0, "R9 pll_rst in reset", np_pll_rst, 0);
    por_n = 1'b1;
    @(negedge clk);
    // R2 settle with restart
    ref_stable = 1'b1;
    repeat (SETTLE - 2) @(negedge clk);
    ref_stable = 1'b0;
    @(negedge clk);
    check(phase == 3'd0, "R2 restart holds RESET", phase, 0);
    ref_stable = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    check(phase == 3'd0, "R2 one edge short", phase, 0);
    @(negedge clk);
    check_outputs(1, "R2 settled");
    check(np_phase == 3'd2, "R9 skip to CLK_WAIT", np_phase, 2);
    // R3 lock gate
    repeat (5) @(negedge clk);
    check(phase == 3'd1, "R3 wait lock", phase, 1);
    pll_locked = 1'b1;
    @(negedge clk);
    check(phase == 3'd2, "R3 locked", phase, 2);
    // R4 aux gate
    aux_stable = 3'b011;
    repeat (6) @(negedge clk);
    check(phase == 3'd2, "R4 partial aux", phase, 2);
    aux_stable = 3'b111;
    @(negedge clk);
    check_outputs(3, "R4 guard entry");
    t0 = int'($time);
    cfg_hold = 1'b1;
    // R5 guard interval
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (core_rst_n) break;
    end
    t1 = int'($time);
    el = t1 - t0;
    check(el >= int'(GUARD * TSLOW), "R5 guard minimum ns", el, GUARD * TSLOW);
    check(el <= int'((GUARD + 4) * TSLOW + 6 * TCLK), "R5 guard bounded ns", el,
          (GUARD + 4) * TSLOW + 6 * TCLK);
    check_outputs(4, "R7 hold after guard");
    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      e = VEC[v];
      pll_locked = e[15];
      aux_stable = e[14:12];
      cfg_hold   = e[11];
      for (int c = 0; c < int'(e[7:0]); c++) begin
        @(negedge clk);
        if (phase == e[10:8]) break;
      end
      check_outputs(int'(e[10:8]), $sformatf("R11 vector %0d", v));
    end
    // R9 no-PLL instance ignores lock and reaches RUN
    cfg_hold = 1'b0;
    repeat (3) @(negedge clk);
    check(np_phase == 3'd5, "R9 no-PLL run", np_phase, 5);
    check(np_core_rst_n == 1'b1, "R9 no-PLL core released", np_core_rst_n, 1);
    check(np_pll_seen == 1'b0, "R9 no-PLL pll_rst stayed low", np_pll_seen, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (R1..all): actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule